// File: doc/BRIEF.md
# Clock Synthesizer Reconfiguration Sequencer

This block drives a reconfigurable clock synthesizer through its memory-mapped register port. A single request strobe starts a sequence. The sequence arms reconfiguration by setting the mode register. It then writes the feedback multiplier (M), the pre-divider (N) and the first output post-divider (C0), and writes the start trigger. Finally it watches the synthesizer's lock indication.

Every write is held on the port until the port stops asserting wait-request. After the start write, the lock input is ignored for a short settle interval, so that a lock left over from the previous setting is not taken as success. Polling then runs for a programmable number of cycles. The block ends by pulsing either a success flag or a timeout flag for one cycle. The choice of divider values belongs to the logic that issues the request.

Top module: `synth_reconf_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `wr_en`, `done_ok` and `done_tmo` are low. Whenever `wr_en` is low, `wr_addr` and `wr_data` read zero.
- R2: A `req` sampled high while `busy` is low is accepted at that clock edge. From the next cycle, `busy` is high and the first write targets address 0 (mode) with data 1.
- R3: Each sequence issues exactly five writes, in this order: address 0 with data 1; address 4 with the M value; address 3 with the N value; address 5 with the C value in bits [8:0] and the counter select (0 for C0) in bits [22:18]; address 2 with data 1.
- R4: While `wait_req` is high, `wr_en`, `wr_addr` and `wr_data` hold their values. A write counts as accepted only in a cycle where `wr_en` is high and `wait_req` is low, and the next write follows in the next cycle.
- R5: A `req` that arrives while `busy` is high is ignored. M, N, C and the timeout are captured when a request is accepted, and changes to those inputs after that point have no effect on the sequence.
- R6: For SETTLE_CYCLES cycles after the start write is accepted, `lock` is ignored. With `lock` held high throughout, a sequence keeps `busy` high for exactly 5 + SETTLE_CYCLES + 2 cycles when no write stalls.
- R7: Polling begins after the settle interval. In the first polling cycle where `lock` is sampled high, `done_ok` pulses in the next cycle.
- R8: If `lock` stays low for the captured timeout number of polling cycles, `done_tmo` pulses in the next cycle. A captured timeout of 0 behaves as 1.
- R9: `done_ok` and `done_tmo` are never high together. Each one lasts exactly one cycle, during which `busy` is still high. In the following cycle `busy` is low and a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a reconfiguration sequence |
| m_val | input | 9 | Feedback multiplier value |
| n_val | input | 9 | Pre-divider value |
| c_val | input | 9 | C0 post-divider value |
| lock_tmo | input | 16 | Polling limit in clock cycles |
| lock | input | 1 | Lock indication from the synthesizer |
| wait_req | input | 1 | Register port is not ready to take the write |
| wr_addr | output | 6 | Register address |
| wr_data | output | 32 | Register write data |
| wr_en | output | 1 | Write strobe |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | One-cycle success pulse |
| done_tmo | output | 1 | One-cycle timeout pulse |

## Verification
The hardest situation to reach is a lock that is already high when the start write lands. That lock must be ignored through the whole settle interval, and this must still hold while random wait-request stalls stretch the writes by unpredictable amounts.

The stimulus keeps `lock` high across an entire sequence and measures the exact busy length. It also runs a sequence with pseudo-random stalls while `lock` rises during the writes. A behavioural model built from a queue of expected writes checks every cycle against the design's outputs.

// File: rtl/synth_reconf_pkg.sv
// Shared types for the synthesizer reconfiguration sequencer.
// Assumes the register port decodes the fixed local addresses below.
package synth_reconf_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_WR_MODE, ST_WR_M, ST_WR_N, ST_WR_C, ST_WR_START,
        ST_SETTLE, ST_POLL, ST_OK, ST_TMO
    } seq_state_t;

    localparam int unsigned ADDR_MODE  = 0;
    localparam int unsigned ADDR_START = 2;
    localparam int unsigned ADDR_N     = 3;
    localparam int unsigned ADDR_M     = 4;
    localparam int unsigned ADDR_C     = 5;
endpackage

// File: rtl/reconf_seq_timer.sv
// Free-running cycle counter, cleared on request or reset.
// Used for the settle interval and the lock poll window.
// Assumes the FSM clears it on every state change.
module reconf_seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // count cycles since the last clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/reconf_seq_fsm.sv
// Sequence controller: orders the writes, waits out the settle interval,
// polls lock against the captured limit and emits the end state.
// Assumes cnt comes from a counter cleared whenever cnt_clr is high, and
// that SETTLE_CYCLES is at least 1 and below 2**TMO_W.
module reconf_seq_fsm
    import synth_reconf_pkg::*;
#(
    parameter int TMO_W         = 16,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wait_req,
    input  logic             lock,
    input  logic [TMO_W-1:0] tmo_lat,
    input  logic [TMO_W-1:0] cnt,
    output seq_state_t       state,
    output logic             accept,
    output logic             cnt_clr
);
    localparam logic [TMO_W-1:0] SETTLE_LAST = TMO_W'(SETTLE_CYCLES - 1);

    seq_state_t nxt;
    logic       poll_expired;

    // limit reached in this polling cycle; a limit of 0 acts as 1
    assign poll_expired = ({1'b0, cnt} + 1'b1) >= {1'b0, tmo_lat};
    assign accept       = (state == ST_IDLE) && req;
    assign cnt_clr      = (nxt != state);

    // next-state selection
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (req)       nxt = ST_WR_MODE;
            ST_WR_MODE:  if (!wait_req) nxt = ST_WR_M;
            ST_WR_M:     if (!wait_req) nxt = ST_WR_N;
            ST_WR_N:     if (!wait_req) nxt = ST_WR_C;
            ST_WR_C:     if (!wait_req) nxt = ST_WR_START;
            ST_WR_START: if (!wait_req) nxt = ST_SETTLE;
            ST_SETTLE:   if (cnt == SETTLE_LAST) nxt = ST_POLL;
            ST_POLL: begin
                if (lock)              nxt = ST_OK;
                else if (poll_expired) nxt = ST_TMO;
            end
            ST_OK, ST_TMO: nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // R6: lock cannot end the sequence straight out of the settle interval
    p_settle_ignores_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SETTLE |=> state != ST_OK);
    // R8: the poll counter never passes the captured limit
    p_poll_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_POLL |-> (cnt < tmo_lat) || (cnt == '0));
    // R8: timeout only when lock was low in the last polling cycle
    p_tmo_lock_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_POLL && lock |=> state == ST_OK);
endmodule

// File: rtl/reconf_seq_wrmux.sv
// Drives the register port from the current write state and the captured
// divider values. The port outputs are zero outside the write states.
// Assumes the select field sits above the C value without overlap.
module reconf_seq_wrmux
    import synth_reconf_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int DIV_W    = 9,
    parameter int CSEL_LSB = 18,
    parameter int CSEL_W   = 5,
    parameter int C_SEL    = 0
) (
    input  seq_state_t        state,
    input  logic [DIV_W-1:0]  m_lat,
    input  logic [DIV_W-1:0]  n_lat,
    input  logic [DIV_W-1:0]  c_lat,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam logic [DATA_W-1:0] SEL_FIELD =
        DATA_W'(CSEL_W'(C_SEL)) << CSEL_LSB;

    // address and data for each write state
    always_comb begin
        wr_en   = 1'b1;
        wr_addr = '0;
        wr_data = '0;
        case (state)
            ST_WR_MODE: begin
                wr_addr = ADDR_W'(ADDR_MODE);
                wr_data = DATA_W'(1);
            end
            ST_WR_M: begin
                wr_addr = ADDR_W'(ADDR_M);
                wr_data = DATA_W'(m_lat);
            end
            ST_WR_N: begin
                wr_addr = ADDR_W'(ADDR_N);
                wr_data = DATA_W'(n_lat);
            end
            ST_WR_C: begin
                wr_addr = ADDR_W'(ADDR_C);
                wr_data = SEL_FIELD | DATA_W'(c_lat);
            end
            ST_WR_START: begin
                wr_addr = ADDR_W'(ADDR_START);
                wr_data = DATA_W'(1);
            end
            default: wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/synth_reconf_seq.sv
// Top of the reconfiguration sequencer. It captures the request operands,
// then runs mode, M, N, C0 and start writes followed by a bounded lock poll.
// Assumes the register port holds wait_req high until it takes a write.
module synth_reconf_seq
    import synth_reconf_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int DATA_W        = 32,
    parameter int DIV_W         = 9,
    parameter int TMO_W         = 16,
    parameter int SETTLE_CYCLES = 4,
    parameter int CSEL_LSB      = 18,
    parameter int CSEL_W        = 5,
    parameter int C_SEL         = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DIV_W-1:0]  m_val,
    input  logic [DIV_W-1:0]  n_val,
    input  logic [DIV_W-1:0]  c_val,
    input  logic [TMO_W-1:0]  lock_tmo,
    input  logic              lock,
    input  logic              wait_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic              busy,
    output logic              done_ok,
    output logic              done_tmo
);
    seq_state_t       state;
    logic             accept;
    logic             cnt_clr;
    logic [TMO_W-1:0] cnt;
    logic [DIV_W-1:0] m_lat, n_lat, c_lat;
    logic [TMO_W-1:0] tmo_lat;

    // capture operands when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_lat   <= '0;
            n_lat   <= '0;
            c_lat   <= '0;
            tmo_lat <= '0;
        end else if (accept) begin
            m_lat   <= m_val;
            n_lat   <= n_val;
            c_lat   <= c_val;
            tmo_lat <= lock_tmo;
        end
    end

    reconf_seq_fsm #(.TMO_W(TMO_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .wait_req(wait_req), .lock(lock),
        .tmo_lat(tmo_lat), .cnt(cnt), .state(state), .accept(accept),
        .cnt_clr(cnt_clr)
    );

    reconf_seq_timer #(.W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
    );

    reconf_seq_wrmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
        .CSEL_LSB(CSEL_LSB), .CSEL_W(CSEL_W), .C_SEL(C_SEL)
    ) u_wrmux (
        .state(state), .m_lat(m_lat), .n_lat(n_lat), .c_lat(c_lat),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // status flags decoded from the state register
    assign busy     = (state != ST_IDLE);
    assign done_ok  = (state == ST_OK);
    assign done_tmo = (state == ST_TMO);

    // R4: a stalled write keeps its address and data
    p_hold_on_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wait_req |=> wr_en && $stable(wr_addr) && $stable(wr_data));
    // R2: a sequence opens with the mode write
    p_first_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wr_en && wr_addr == ADDR_W'(ADDR_MODE) && wr_data == DATA_W'(1));
    // R3: the accepted mode write is followed by the M write
    p_mode_then_m_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wait_req && wr_addr == ADDR_W'(ADDR_MODE) |=> wr_addr == ADDR_W'(ADDR_M));
    // R3: the accepted C write is followed by the start write
    p_c_then_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wait_req && wr_addr == ADDR_W'(ADDR_C) |=> wr_addr == ADDR_W'(ADDR_START));
    // R5: captured operands do not move during a sequence
    p_operands_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(m_lat) && $stable(n_lat) && $stable(c_lat) && $stable(tmo_lat));
    // R9: end flags are exclusive
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_tmo));
    // R9: an end flag lasts one cycle and is followed by idle
    p_pulse_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok || done_tmo |=> !done_ok && !done_tmo && !busy);
endmodule

// File: tb/tb_synth_reconf_seq.sv
module tb_synth_reconf_seq;
    localparam int SETTLE = 4;
    localparam longint C_SEL_FIELD = 0;   // C0 select in bits [22:18]

    logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, lock = 1'b0, wait_req = 1'b0;
    logic [8:0]  m_in = '0, n_in = '0, c_in = '0;
    logic [15:0] tmo_in = '0;
    logic [5:0]  wr_addr;
    logic [31:0] wr_data;
    logic        wr_en, busy, done_ok, done_tmo;

    synth_reconf_seq #(.SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .m_val(m_in), .n_val(n_in),
        .c_val(c_in), .lock_tmo(tmo_in), .lock(lock), .wait_req(wait_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .busy(busy),
        .done_ok(done_ok), .done_tmo(done_tmo)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    int ok_cnt = 0, tmo_cnt = 0, busy_cyc = 0;

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 writing, 2 settle, 3 poll, 4 ok, 5 timeout
    int     ms = 0, sc = 0, pc = 0, tmo_l = 1;
    int     q_addr[$];
    longint q_data[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; q_addr.delete(); q_data.delete();
        end else begin
            case (ms)
                0: if (req) begin
                    q_addr = '{0, 4, 3, 5, 2};
                    q_data = '{1, longint'(m_in), longint'(n_in),
                               (C_SEL_FIELD << 18) | longint'(c_in), 1};
                    tmo_l = (tmo_in == 0) ? 1 : int'(tmo_in);
                    ms = 1;
                end
                1: if (!wait_req) begin
                    void'(q_addr.pop_front()); void'(q_data.pop_front());
                    if (q_addr.size() == 0) begin ms = 2; sc = 0; end
                end
                2: begin sc++; if (sc == SETTLE) begin ms = 3; pc = 0; end end
                3: if (lock) ms = 4;
                   else begin pc++; if (pc >= tmo_l) ms = 5; end
                default: ms = 0;
            endcase
        end
    end

    // per-cycle comparison against the reference, away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            string  tag;
            longint exp_v, act_v;
            case (ms)
                0: tag = "R1/R5"; 1: tag = "R3/R4"; 2: tag = "R6";
                3: tag = "R7/R8"; default: tag = "R9";
            endcase
            exp_v = {longint'(ms != 0), longint'(ms == 1), longint'(ms == 4), longint'(ms == 5)};
            exp_v = ((ms != 0 ? 64'd8 : 0) | (ms == 1 ? 64'd4 : 0) | (ms == 4 ? 64'd2 : 0) | (ms == 5 ? 64'd1 : 0)) << 38;
            if (ms == 1) exp_v = exp_v | (longint'(q_addr[0]) << 32) | q_data[0];
            act_v = ({busy, wr_en, done_ok, done_tmo} << 38) | (longint'(wr_addr) << 32) | longint'(wr_data);
            check(tag, act_v, exp_v);
            if (done_ok) ok_cnt++;
            if (done_tmo) tmo_cnt++;
            if (busy) busy_cyc++;
        end
    end

    // pseudo-random wait-request source
    logic       stall_en = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    always @(posedge clk) begin
        #5;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        wait_req = stall_en & lfsr[0];
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #5; end
    endtask

    task automatic start_req(int m, int n, int c, int t);
        m_in = 9'(m); n_in = 9'(n); c_in = 9'(c); tmo_in = 16'(t);
        req = 1'b1; step(); req = 1'b0;
    endtask

    task automatic wait_idle();
        step();
        for (int i = 0; i < 5000 && busy; i++) step();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(3);
        // R1: reset state on the ports
        check("R1 busy", busy, 0);
        check("R1 wr_en", wr_en, 0);
        check("R1 flags", {done_ok, done_tmo}, 0);
        check("R1 port idle", {wr_addr, wr_data}, 0);
        rst_n = 1'b1; step(2);

        // R2/R3/R7: plain sequence, lock rises while polling
        busy_cyc = 0;
        start_req(40, 2, 5, 50);
        check("R2 busy after accept", busy, 1);
        step(14); lock = 1'b1;
        wait_idle(); lock = 1'b0;
        check("R7 ok count", ok_cnt, 1);

        // R4: random stalls on every write, lock rises mid-sequence
        stall_en = 1'b1;
        start_req(100, 3, 7, 200);
        step(40); lock = 1'b1;
        wait_idle(); lock = 1'b0; stall_en = 1'b0;
        check("R4 ok after stalls", ok_cnt, 2);

        // R5: requests and operand changes while busy are ignored
        start_req(11, 12, 13, 30);
        m_in = 9'd200; n_in = 9'd201; c_in = 9'd202; req = 1'b1;
        step(3); req = 1'b0;
        step(12); lock = 1'b1;
        wait_idle(); lock = 1'b0;
        step(2);
        check("R5 no extra sequence", busy, 0);
        check("R5 single ok", ok_cnt, 3);

        // R6: stale lock held high throughout
        lock = 1'b1; busy_cyc = 0;
        start_req(50, 1, 4, 100);
        wait_idle();
        check("R6 busy length", busy_cyc, 5 + SETTLE + 2);
        check("R6 ok count", ok_cnt, 4);
        lock = 1'b0;

        // R8: timeout after the captured limit
        busy_cyc = 0;
        start_req(60, 2, 3, 20);
        tmo_in = 16'd3;
        wait_idle();
        check("R8 timeout count", tmo_cnt, 1);
        check("R8 busy length", busy_cyc, 5 + SETTLE + 20 + 1);

        // R8: limit of zero acts as one polling cycle
        busy_cyc = 0;
        start_req(60, 2, 3, 0);
        wait_idle();
        check("R8 zero limit count", tmo_cnt, 2);
        check("R8 zero limit length", busy_cyc, 5 + SETTLE + 1 + 1);

        // R9: request held high restarts right after each end pulse
        lock = 1'b1;
        m_in = 9'd9; n_in = 9'd1; c_in = 9'd2; tmo_in = 16'd10;
        req = 1'b1; step(30); req = 1'b0;
        wait_idle(); lock = 1'b0;
        check("R9 back-to-back ok pulses", ok_cnt, 7);
        step(3);
        finish_run();
    end
endmodule